// File: doc/BRIEF.md
# Serial Register Access Slave

This block is the serial front end of a peripheral whose settings live in a bank of 16-bit control registers. A host drives clock, data and an active-low select. The block frames instructions between a falling and a rising select, takes the first byte as an opcode, and then reads or writes a register, sets or clears masked register bits, issues a soft reset, or streams bytes into an external buffer through a pointer that advances by itself.

The select, clock and data inputs are oversampled by the system clock through two-stage synchronizers. The host must therefore hold each clock level for at least three system clock periods. Registers are addressed by byte address with 2-byte granularity. Masked set and clear are done inside the block in one cycle, so the register contents cannot change between the read and the write. The whole register bank is presented to the peripheral on one flat output. The buffer pointer is one of the registers.

Top module: `spi_regslave`

## Requirements
- R1: Bits are taken on rising edges of `spi_sck` (idle low), most significant bit first, and a byte counts only while `spi_cs_n` is low.
- R2: Opcode 20h, then an address byte, then two dummy bytes, returns the addressed register on `spi_miso`: low byte during byte 3 and high byte during byte 4. Each bit is valid before the rising edge that samples it. Register index is address bit 7..1, and bit 0 is ignored. An address of A0h or above reads 0000h.
- R3: Opcode 22h, address, low byte, high byte writes the 16-bit value when the fourth byte completes.
- R4: Opcode 24h, address, mask low, mask high sets every register bit whose mask bit is 1 and leaves the others unchanged.
- R5: Opcode 26h, address, mask low, mask high clears every register bit whose mask bit is 1 and leaves the others unchanged.
- R6: Opcode CAh returns every register to its default, {A5h, register index}. Any further bytes in the same frame are ignored.
- R7: Write, set and clear instructions aimed at address A0h or above change nothing.
- R8: Opcode 2Ah is followed by any number of data bytes. Each completed data byte produces one `buf_we` pulse, with `buf_wdata` equal to the byte and `buf_addr` equal to the low 15 bits of the pointer register (byte address 16h). The pointer register then increments by one, with a 16-bit wrap.
- R9: An unknown opcode makes the block ignore every byte until the select is released.
- R10: Releasing the select before an instruction's last byte completes aborts it with no update. A rising clock edge that reaches the block together with the select release does not complete a byte.
- R11: `spi_miso_oe` is 0 while the select is high and 1 while it is low, following the pin after the synchronizer delay.
- R12: After `rst_n` is asserted, every register holds its default, `spi_miso_oe` is 0 and `buf_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low select that frames one instruction |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| buf_we | output | 1 | One-cycle buffer write strobe |
| buf_addr | output | 15 | Buffer byte address (low bits of the pointer register) |
| buf_wdata | output | 8 | Buffer write data |
| regs_o | output | 1280 | All registers, register i at bits 16i+15..16i |

## Verification
The hazard that shares a cycle is a byte completion and a frame end. The final rising clock edge of an instruction and the select release can leave the synchronizers in the same system cycle. In that case the block must not decide both to commit and to return to idle. The bench provokes this by driving the last rising edge of a set instruction and the select release at the same instant. It then checks through `regs_o` and a read-back that the register kept its old value. A truncated frame and a frame after an unknown opcode are judged the same way against a register model kept in the bench.

// File: rtl/spi_regslave_pkg.sv
package spi_regslave_pkg;

    localparam logic [7:0] OP_READ  = 8'h20;
    localparam logic [7:0] OP_WRITE = 8'h22;
    localparam logic [7:0] OP_SET   = 8'h24;
    localparam logic [7:0] OP_CLR   = 8'h26;
    localparam logic [7:0] OP_BUFWR = 8'h2A;
    localparam logic [7:0] OP_RESET = 8'hCA;

    typedef enum logic [2:0] {
        ST_OP, ST_ADDR, ST_LO, ST_HI, ST_STREAM, ST_IGNORE
    } frame_st_e;

    typedef enum logic [2:0] {
        CMD_WRITE, CMD_SET, CMD_CLR, CMD_RESET, CMD_PTRINC
    } cmd_kind_e;

    // Default content of register idx.
    function automatic logic [15:0] reg_default(input int idx);
        return {8'hA5, 8'(idx)};
    endfunction

endpackage

// File: rtl/spi_regslave_sync.sv
module spi_regslave_sync #(
    parameter int               WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [1:0] stage_d, stage_q;
        always_comb stage_d = {stage_q[0], din[g]};
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= {2{RST_VAL[g]}};
            else        stage_q <= stage_d;
        end
        assign dout[g] = stage_q[1];
    end
endmodule

// File: rtl/spi_regslave_frame.sv
module spi_regslave_frame
    import spi_regslave_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_s,
    input  logic        sck_s,
    input  logic        mosi_s,
    input  logic [15:0] rd_data,
    output logic [7:0]  rd_addr,
    output logic        cmd_valid,
    output cmd_kind_e   cmd_kind,
    output logic [7:0]  cmd_addr,
    output logic [15:0] cmd_data,
    output logic        buf_we,
    output logic [7:0]  buf_wdata,
    output logic        miso
);
    typedef struct packed {
        frame_st_e   st;
        logic [2:0]  bit_cnt;
        logic [7:0]  rx;
        logic [7:0]  op;
        logic [7:0]  addr;
        logic [7:0]  lo;
        logic [15:0] tx;
        logic        sck_prev;
    } frame_t;

    frame_t q, d;
    logic       rise, byte_done;
    logic [7:0] new_byte;

    assign rise      = sck_s & ~q.sck_prev;
    assign byte_done = rise & ~cs_s & (q.bit_cnt == 3'd7);
    assign new_byte  = {q.rx[6:0], mosi_s};
    assign rd_addr   = new_byte;
    assign miso      = q.tx[15];
    assign cmd_addr  = q.addr;

    always_comb begin
        d          = q;
        d.sck_prev = sck_s;
        cmd_valid  = 1'b0;
        cmd_kind   = CMD_WRITE;
        cmd_data   = {new_byte, q.lo};
        buf_we     = 1'b0;
        buf_wdata  = new_byte;
        if (cs_s) begin
            // frame idle or released: drop any partial instruction
            d.st      = ST_OP;
            d.bit_cnt = 3'd0;
            d.tx      = '0;
        end else if (rise) begin
            d.bit_cnt = q.bit_cnt + 3'd1;
            d.rx      = new_byte;
            if (q.st == ST_LO || q.st == ST_HI) d.tx = {q.tx[14:0], 1'b0};
            if (byte_done) begin
                case (q.st)
                    ST_OP: begin
                        d.op = new_byte;
                        case (new_byte)
                            OP_RESET: begin
                                cmd_valid = 1'b1;
                                cmd_kind  = CMD_RESET;
                                d.st      = ST_IGNORE;
                            end
                            OP_READ, OP_WRITE, OP_SET, OP_CLR: d.st = ST_ADDR;
                            OP_BUFWR: d.st = ST_STREAM;
                            default:  d.st = ST_IGNORE;
                        endcase
                    end
                    ST_ADDR: begin
                        d.addr = new_byte;
                        d.st   = ST_LO;
                        if (q.op == OP_READ) d.tx = {rd_data[7:0], rd_data[15:8]};
                    end
                    ST_LO: begin
                        d.lo = new_byte;
                        d.st = ST_HI;
                    end
                    ST_HI: begin
                        d.st = ST_IGNORE;
                        if (q.op != OP_READ) begin
                            cmd_valid = 1'b1;
                            cmd_kind  = (q.op == OP_SET) ? CMD_SET :
                                        (q.op == OP_CLR) ? CMD_CLR : CMD_WRITE;
                        end
                    end
                    ST_STREAM: begin
                        buf_we    = 1'b1;
                        cmd_valid = 1'b1;
                        cmd_kind  = CMD_PTRINC;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_OP, default: '0};
        else        q <= d;
    end
endmodule

// File: rtl/spi_regslave_regbank.sv
module spi_regslave_regbank
    import spi_regslave_pkg::*;
#(
    parameter int         REG_BYTES = 160,
    parameter logic [7:0] PTR_ADDR  = 8'h16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  cmd_kind_e              cmd_kind,
    input  logic [7:0]             cmd_addr,
    input  logic [15:0]            cmd_data,
    input  logic [7:0]             rd_addr,
    output logic [15:0]            rd_data,
    output logic [15:0]            ptr,
    output logic [REG_BYTES*8-1:0] regs_flat
);
    localparam int NUM_REGS = REG_BYTES / 2;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int PTR_IDX  = int'(PTR_ADDR) / 2;

    logic [15:0] regs_q [NUM_REGS];
    logic [15:0] regs_d [NUM_REGS];
    logic        wr_ok;
    logic [IDX_W-1:0] wr_idx;

    assign wr_ok  = int'(cmd_addr) < REG_BYTES;
    assign wr_idx = cmd_addr[IDX_W:1];

    always_comb begin
        regs_d = regs_q;
        if (cmd_valid) begin
            case (cmd_kind)
                CMD_RESET:  for (int i = 0; i < NUM_REGS; i++) regs_d[i] = reg_default(i);
                CMD_PTRINC: regs_d[PTR_IDX] = regs_q[PTR_IDX] + 16'd1;
                CMD_WRITE:  if (wr_ok) regs_d[wr_idx] = cmd_data;
                CMD_SET:    if (wr_ok) regs_d[wr_idx] = regs_q[wr_idx] | cmd_data;
                CMD_CLR:    if (wr_ok) regs_d[wr_idx] = regs_q[wr_idx] & ~cmd_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= reg_default(i);
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_data = (int'(rd_addr) < REG_BYTES) ? regs_q[rd_addr[IDX_W:1]] : 16'h0000;
    assign ptr     = regs_q[PTR_IDX];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign regs_flat[g*16 +: 16] = regs_q[g];
    end
endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
    import spi_regslave_pkg::*;
#(
    parameter int         REG_BYTES = 160,
    parameter logic [7:0] PTR_ADDR  = 8'h16,
    parameter int         BUF_AW    = 15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   spi_sck,
    input  logic                   spi_cs_n,
    input  logic                   spi_mosi,
    output logic                   spi_miso,
    output logic                   spi_miso_oe,
    output logic                   buf_we,
    output logic [BUF_AW-1:0]      buf_addr,
    output logic [7:0]             buf_wdata,
    output logic [REG_BYTES*8-1:0] regs_o
);
    logic        cs_s, sck_s, mosi_s;
    logic [7:0]  rd_addr;
    logic [15:0] rd_data, ptr;
    logic        cmd_valid;
    cmd_kind_e   cmd_kind;
    logic [7:0]  cmd_addr;
    logic [15:0] cmd_data;
    logic        unused_ptr_bits;

    spi_regslave_sync #(.WIDTH(3), .RST_VAL(3'b100)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_cs_n, spi_sck, spi_mosi}),
        .dout ({cs_s, sck_s, mosi_s})
    );

    spi_regslave_frame frame_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_s     (cs_s),
        .sck_s    (sck_s),
        .mosi_s   (mosi_s),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .cmd_valid(cmd_valid),
        .cmd_kind (cmd_kind),
        .cmd_addr (cmd_addr),
        .cmd_data (cmd_data),
        .buf_we   (buf_we),
        .buf_wdata(buf_wdata),
        .miso     (spi_miso)
    );

    spi_regslave_regbank #(.REG_BYTES(REG_BYTES), .PTR_ADDR(PTR_ADDR)) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_kind (cmd_kind),
        .cmd_addr (cmd_addr),
        .cmd_data (cmd_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .ptr      (ptr),
        .regs_flat(regs_o)
    );

    assign spi_miso_oe     = ~cs_s;
    assign buf_addr        = ptr[BUF_AW-1:0];
    assign unused_ptr_bits = ^ptr[15:BUF_AW];
endmodule

// File: rtl/spi_regslave_chk.sv
module spi_regslave_chk
    import spi_regslave_pkg::*;
#(
    parameter int REG_BYTES = 160,
    parameter int BUF_AW    = 15
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   spi_cs_n,
    input logic                   spi_miso_oe,
    input logic                   buf_we,
    input logic [BUF_AW-1:0]      buf_addr,
    input logic [REG_BYTES*8-1:0] regs_o,
    input logic                   cmd_valid,
    input cmd_kind_e              cmd_kind,
    input logic [7:0]             cmd_addr,
    input logic [15:0]            cmd_data
);
    logic [2:0]        age_q;
    logic              pend_q;
    cmd_kind_e         pkind_q;
    logic [7:0]        pidx_q;
    logic [15:0]       old_q, mask_q, cur_word;
    logic              seen_q;
    logic [BUF_AW-1:0] last_q;
    logic              tgt_ok;

    assign tgt_ok   = int'(cmd_addr) < REG_BYTES;
    assign cur_word = regs_o[int'(pidx_q)*16 +: 16];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q   <= '0;
            pend_q  <= 1'b0;
            pkind_q <= CMD_WRITE;
            pidx_q  <= '0;
            old_q   <= '0;
            mask_q  <= '0;
            seen_q  <= 1'b0;
            last_q  <= '0;
        end else begin
            if (age_q != 3'd7) age_q <= age_q + 3'd1;
            pend_q <= cmd_valid && tgt_ok &&
                      (cmd_kind == CMD_WRITE || cmd_kind == CMD_SET || cmd_kind == CMD_CLR);
            pkind_q <= cmd_kind;
            pidx_q  <= {1'b0, cmd_addr[7:1]};
            mask_q  <= cmd_data;
            if (tgt_ok) old_q <= regs_o[int'(cmd_addr[7:1])*16 +: 16];
            if (!spi_miso_oe) seen_q <= 1'b0;
            else if (buf_we)  seen_q <= 1'b1;
            if (buf_we) last_q <= buf_addr;
        end
    end

    a_r3_write_value: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && pkind_q == CMD_WRITE) |-> (cur_word == mask_q));

    a_r4_set_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && pkind_q == CMD_SET) |-> (cur_word == (old_q | mask_q)));

    a_r5_clear_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && pkind_q == CMD_CLR) |-> (cur_word == (old_q & ~mask_q)));

    a_r8_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && seen_q) |-> (buf_addr == last_q + 1'b1));

    a_r11_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd4 && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
        |-> !spi_miso_oe);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd6 && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)
         && $past(spi_cs_n, 4)) |-> (!buf_we && $stable(regs_o)));
endmodule

bind spi_regslave spi_regslave_chk #(.REG_BYTES(REG_BYTES), .BUF_AW(BUF_AW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_cs_n   (spi_cs_n),
    .spi_miso_oe(spi_miso_oe),
    .buf_we     (buf_we),
    .buf_addr   (buf_addr),
    .regs_o     (regs_o),
    .cmd_valid  (cmd_valid),
    .cmd_kind   (cmd_kind),
    .cmd_addr   (cmd_addr),
    .cmd_data   (cmd_data)
);

// File: tb/spi_regslave_tb_top.sv
module spi_regslave_tb_top;
    localparam int NREG = 80;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_mosi = 1'b0;
    logic spi_miso, spi_miso_oe, buf_we;
    logic [14:0] buf_addr;
    logic [7:0]  buf_wdata;
    logic [NREG*16-1:0] regs_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] model [NREG];
    int          bw_n = 0;
    logic [14:0] bw_addr [16];
    logic [7:0]  bw_data [16];

    spi_regslave dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .regs_o(regs_o)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && buf_we) begin
            if (bw_n < 16) begin
                bw_addr[bw_n] = buf_addr;
                bw_data[bw_n] = buf_wdata;
            end
            bw_n++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] dflt(input int i);
        return {8'hA5, 8'(i)};
    endfunction

    task automatic check_all(input string req);
        for (int i = 0; i < NREG; i++) check(req, {16'h0, regs_o[i*16 +: 16]}, {16'h0, model[i]});
    endtask

    task automatic xfer(input logic [7:0] tx, input bit cut, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            spi_mosi = tx[b];
            repeat (HALF) @(negedge clk);
            rx[b] = spi_miso;
            if (cut && b == 0) spi_cs_n = 1'b1;
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
    endtask

    task automatic open_frame();
        spi_cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic close_frame();
        repeat (2) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic instr4(input logic [7:0] op, input logic [7:0] a, input logic [15:0] v);
        logic [7:0] r;
        open_frame();
        xfer(op, 1'b0, r); xfer(a, 1'b0, r); xfer(v[7:0], 1'b0, r); xfer(v[15:8], 1'b0, r);
        close_frame();
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] v);
        logic [7:0] r, lo, hi;
        open_frame();
        xfer(8'h20, 1'b0, r); xfer(a, 1'b0, r); xfer(8'h00, 1'b0, lo); xfer(8'h00, 1'b0, hi);
        close_frame();
        v = {hi, lo};
    endtask

    initial begin
        logic [15:0] v;
        logic [7:0]  r;
        int bw0;
        for (int i = 0; i < NREG; i++) model[i] = dflt(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R12: reset state
        check("R12 oe", {31'h0, spi_miso_oe}, 32'h0);
        check("R12 buf_we", {31'h0, buf_we}, 32'h0);
        check_all("R12 defaults");

        // R11: enable follows select
        spi_cs_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R11 oe low-select", {31'h0, spi_miso_oe}, 32'h1);
        spi_cs_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R11 oe high-select", {31'h0, spi_miso_oe}, 32'h0);

        // R1/R2: read default through MISO, odd address, out of range
        rd(8'h16, v); check("R2 read ptr default", {16'h0, v}, {16'h0, dflt(11)});
        rd(8'h17, v); check("R2 odd address", {16'h0, v}, {16'h0, dflt(11)});
        rd(8'hA0, v); check("R2 addr A0h", {16'h0, v}, 32'h0);
        rd(8'hFF, v); check("R2 addr FFh", {16'h0, v}, 32'h0);
        instr4(8'h22, 8'h30, 16'h8001);
        rd(8'h30, v); check("R1 bit order", {16'h0, v}, 32'h8001);
        model[24] = 16'h8001;

        // R3: write sweep then read-back sweep
        for (int i = 0; i < NREG; i++) begin
            logic [15:0] w;
            w = 16'h3C00 ^ 16'(i * 16'h0109);
            instr4(8'h22, 8'(2 * i), w);
            model[i] = w;
        end
        check_all("R3 write sweep");
        for (int i = 0; i < NREG; i++) begin
            rd(8'(2 * i), v);
            check("R2 read sweep", {16'h0, v}, {16'h0, model[i]});
        end

        // R4/R5: masked set and clear on several patterns
        for (int k = 0; k < 6; k++) begin
            int idx;
            logic [15:0] m;
            idx = 3 + 9 * k;
            m = 16'h0F0F << k;
            instr4(8'h24, 8'(2 * idx), m);
            model[idx] = model[idx] | m;
            check("R4 set", {16'h0, regs_o[idx*16 +: 16]}, {16'h0, model[idx]});
            m = 16'hA5A5 >> k;
            instr4(8'h26, 8'(2 * idx + 1), m);
            model[idx] = model[idx] & ~m;
            rd(8'(2 * idx), v);
            check("R5 clear", {16'h0, v}, {16'h0, model[idx]});
        end

        // R7: out-of-range writes, sets and clears
        instr4(8'h22, 8'hA0, 16'hFFFF);
        instr4(8'h24, 8'hC4, 16'hFFFF);
        instr4(8'h26, 8'hFE, 16'hFFFF);
        check_all("R7 out of range");

        // R9: unknown opcode, rest looks like a write
        bw0 = bw_n;
        open_frame();
        xfer(8'h55, 1'b0, r); xfer(8'h22, 1'b0, r); xfer(8'h10, 1'b0, r);
        xfer(8'h12, 1'b0, r); xfer(8'h34, 1'b0, r); xfer(8'h2A, 1'b0, r);
        close_frame();
        check_all("R9 unknown opcode");
        check("R9 no buffer write", bw_n, bw0);

        // R10: truncated write
        open_frame();
        xfer(8'h22, 1'b0, r); xfer(8'h10, 1'b0, r); xfer(8'h77, 1'b0, r);
        close_frame();
        check("R10 truncated", {16'h0, regs_o[8*16 +: 16]}, {16'h0, model[8]});
        // R10: last rising edge coincides with select release
        open_frame();
        xfer(8'h24, 1'b0, r); xfer(8'h10, 1'b0, r); xfer(8'hFF, 1'b0, r); xfer(8'hFF, 1'b1, r);
        repeat (8) @(negedge clk);
        check("R10 coincident release", {16'h0, regs_o[8*16 +: 16]}, {16'h0, model[8]});
        rd(8'h10, v); check("R10 read-back", {16'h0, v}, {16'h0, model[8]});

        // R8: stream through pointer across the 15-bit wrap
        instr4(8'h22, 8'h16, 16'h7FFE);
        model[11] = 16'h7FFE;
        bw0 = bw_n;
        open_frame();
        xfer(8'h2A, 1'b0, r);
        for (int k = 0; k < 5; k++) xfer(8'(8'h11 + k), 1'b0, r);
        close_frame();
        check("R8 count", bw_n - bw0, 5);
        for (int k = 0; k < 5; k++) begin
            check("R8 addr", {17'h0, bw_addr[bw0 + k]}, {17'h0, 15'(16'h7FFE + k)});
            check("R8 data", {24'h0, bw_data[bw0 + k]}, {24'h0, 8'(8'h11 + k)});
        end
        model[11] = 16'h8003;
        rd(8'h16, v); check("R8 pointer after", {16'h0, v}, 32'h8003);

        // R6: soft reset, trailing bytes ignored
        open_frame();
        xfer(8'hCA, 1'b0, r); xfer(8'h22, 1'b0, r); xfer(8'h16, 1'b0, r);
        xfer(8'hFF, 1'b0, r); xfer(8'hFF, 1'b0, r);
        close_frame();
        for (int i = 0; i < NREG; i++) model[i] = dflt(i);
        check_all("R6 soft reset");
        rd(8'h16, v); check("R6 pointer default", {16'h0, v}, {16'h0, dflt(11)});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule